// File: doc/BRIEF.md
# Chained Buffer Descriptor Scanner

The scanner is the control half of one channel of a stream-moving DMA. Software supplies two circular arrays of 64-bit buffer descriptors: one describes source buffers and one describes destination buffers. Each descriptor sits in its own 64-byte slot. Bit 63 of a descriptor is its state flag, where 1 means the buffer holds data and 0 means it is free. Bits 47:0 carry the buffer's physical address. The scanner reads descriptors through a request/response port. It looks for a full source buffer and an empty destination buffer, then hands the two addresses to an external copy engine. When the copy finishes, it writes both descriptors back with their flags inverted. It then keeps going without software involvement.

There are two scan policies, and the retry period input selects between them. When the period is nonzero, each array is walked strictly in order. A descriptor that is not ready is read again after a pause. When the period is zero, the scanner moves straight on to the next slot on a miss. This gives a round-robin search that resumes after the last slot it used.

The controller is a single state machine with these states:
- `S_IDLE`
- `S_SRC_REQ`, `S_SRC_RSP`, `S_SRC_WAIT`
- `S_DST_REQ`, `S_DST_RSP`, `S_DST_WAIT`
- `S_COPY_GO`, `S_COPY_WAIT`
- `S_SRC_UPD_REQ`, `S_SRC_UPD_RSP`, `S_DST_UPD_REQ`, `S_DST_UPD_RSP`
- four error states: `S_ERR_SRC_DESC`, `S_ERR_DST_DESC`, `S_ERR_SRC_DATA`, `S_ERR_DST_DATA`

Transitions:
- IDLE moves to SRC_REQ when run is set.
- Each REQ state moves to its RSP state when the request is accepted.
- SRC_RSP moves to DST_REQ on a full source. On an empty source it moves to SRC_WAIT (in-order mode) or back to SRC_REQ (round-robin mode).
- DST_RSP moves to COPY_GO on an empty destination, or to DST_WAIT or DST_REQ otherwise.
- The WAIT states return to their REQ state when the timer expires.
- COPY_GO moves to COPY_WAIT.
- On copy completion, the machine moves to SRC_UPD_REQ, or to a data error state if the copy engine reports one.
- SRC_UPD_RSP leads to DST_UPD_REQ.
- DST_UPD_RSP leads back to SRC_REQ.
- A bus error on any response leads to the matching descriptor error state.
- A low run input leads to IDLE from every state.

Top module: `chbuf_scanner`

## Requirements
- R1: Descriptor number i of an array is requested at array base + 64*i, and the copy addresses handed to the copy engine are bits 47:0 of the chosen source and destination descriptors.
- R2: A source descriptor is ready when bit 63 is 1; a destination descriptor is ready when bit 63 is 0.
- R3: With period 0, each array is searched from the slot after the last one used (slot 0 after run is raised), skipping slots that are not ready, and the slot index wraps to 0 after buffer count minus 1.
- R4: With a nonzero period, slots are used strictly in order; after a not-ready response the same descriptor is requested again after exactly period idle cycles, and no later slot is taken instead.
- R5: After a successful copy, the source descriptor is written with bit 63 cleared and then the destination descriptor is written with bit 63 set, bits 62:0 of each unchanged.
- R6: copy_start is a one-cycle pulse and no new copy starts before copy_done.
- R7: A memory request keeps valid, address, write flag and write data stable until it is accepted.
- R8: A bus error on a source descriptor read or write gives status 2, and on a destination descriptor read or write gives status 3.
- R9: A copy reported with a source-side error gives status 4 and with only a destination-side error gives status 5; a source-side error wins when both are flagged.
- R10: irq is high exactly while the status is an error code (2 to 5), and an error status persists while run stays high.
- R11: Run low forces status 0 (idle) on the next cycle from any state, and a copy completion arriving afterwards changes no descriptor.
- R12: After reset, status is 0 (idle), irq is low and neither a memory request nor copy_start is asserted; a running channel reports status 1 (busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_run | input | 1 | Channel enable; low forces idle |
| cfg_src_base | input | ADDR_W | Source descriptor array base, 64-byte aligned |
| cfg_dst_base | input | ADDR_W | Destination descriptor array base, 64-byte aligned |
| cfg_nbufs | input | NBUF_W | Number of slots in each array |
| cfg_period | input | PERIOD_W | Retry pause in cycles; 0 selects round-robin search |
| mem_req_valid | output | 1 | Descriptor access request |
| mem_req_ready | input | 1 | Request accepted this cycle |
| mem_req_write | output | 1 | 1 for a descriptor write, 0 for a read |
| mem_req_addr | output | ADDR_W | Descriptor byte address |
| mem_req_wdata | output | 64 | Descriptor write value |
| mem_rsp_valid | input | 1 | Response for the last accepted request |
| mem_rsp_rdata | input | 64 | Read descriptor value |
| mem_rsp_err | input | 1 | Bus error on this response |
| copy_start | output | 1 | One-cycle copy launch |
| copy_src_addr | output | 48 | Source buffer address |
| copy_dst_addr | output | 48 | Destination buffer address |
| copy_done | input | 1 | Copy finished |
| copy_src_err | input | 1 | Copy failed reading the source (valid with copy_done) |
| copy_dst_err | input | 1 | Copy failed writing the destination (valid with copy_done) |
| status | output | 3 | 0 idle, 1 busy, 2 src desc err, 3 dst desc err, 4 src data err, 5 dst data err |
| irq | output | 1 | Error interrupt for this channel |

## Verification
The assertions assume the environment follows the port protocol:
- every accepted request gets exactly one response;
- copy_done arrives only after a copy_start;
- the configuration inputs change only while run is low.

The bench keeps to these rules:
- Its memory model answers one cycle after acceptance.
- The copy model raises copy_done a fixed latency after each launch.
- Configuration changes happen only with run low. While running, only descriptor contents are reloaded.

Request stalls come from a ready line that toggles every cycle, which exercises the hold rule without breaking the one-response rule.

// File: rtl/chbuf_scan_pkg.sv
package chbuf_scan_pkg;

    localparam int DESC_W     = 64;
    localparam int FLAG_BIT   = 63;
    localparam int BUF_ADDR_W = 48;
    localparam int SLOT_SHIFT = 6;

    typedef enum logic [4:0] {
        S_IDLE,
        S_SRC_REQ,
        S_SRC_RSP,
        S_SRC_WAIT,
        S_DST_REQ,
        S_DST_RSP,
        S_DST_WAIT,
        S_COPY_GO,
        S_COPY_WAIT,
        S_SRC_UPD_REQ,
        S_SRC_UPD_RSP,
        S_DST_UPD_REQ,
        S_DST_UPD_RSP,
        S_ERR_SRC_DESC,
        S_ERR_DST_DESC,
        S_ERR_SRC_DATA,
        S_ERR_DST_DATA
    } scan_state_e;

    typedef enum logic [2:0] {
        CH_IDLE          = 3'd0,
        CH_BUSY          = 3'd1,
        CH_SRC_DESC_ERR  = 3'd2,
        CH_DST_DESC_ERR  = 3'd3,
        CH_SRC_DATA_ERR  = 3'd4,
        CH_DST_DATA_ERR  = 3'd5
    } chan_status_e;

endpackage

// File: rtl/chbuf_ring_index.sv
module chbuf_ring_index #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         advance,
    input  logic [W-1:0] limit,
    output logic [W-1:0] idx
);

    logic at_last;

    assign at_last = (idx >= limit - W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (advance) begin
            idx <= at_last ? '0 : idx + W'(1);
        end
    end

    // R3: the last slot is followed by slot 0
    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && limit != '0 && idx == limit - W'(1)) |=> idx == '0);

endmodule

// File: rtl/chbuf_poll_timer.sv
module chbuf_poll_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = tick && (cnt_q <= W'(1));

endmodule

// File: rtl/chbuf_scanner.sv
module chbuf_scanner
    import chbuf_scan_pkg::*;
#(
    parameter int ADDR_W   = 48,
    parameter int NBUF_W   = 8,
    parameter int PERIOD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_run,
    input  logic [ADDR_W-1:0]     cfg_src_base,
    input  logic [ADDR_W-1:0]     cfg_dst_base,
    input  logic [NBUF_W-1:0]     cfg_nbufs,
    input  logic [PERIOD_W-1:0]   cfg_period,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_write,
    output logic [ADDR_W-1:0]     mem_req_addr,
    output logic [DESC_W-1:0]     mem_req_wdata,
    input  logic                  mem_rsp_valid,
    input  logic [DESC_W-1:0]     mem_rsp_rdata,
    input  logic                  mem_rsp_err,
    output logic                  copy_start,
    output logic [BUF_ADDR_W-1:0] copy_src_addr,
    output logic [BUF_ADDR_W-1:0] copy_dst_addr,
    input  logic                  copy_done,
    input  logic                  copy_src_err,
    input  logic                  copy_dst_err,
    output logic [2:0]            status,
    output logic                  irq
);

    localparam int OFS_W   = NBUF_W + SLOT_SHIFT;
    localparam int SIDE_N  = 2;
    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;

    scan_state_e state_q, state_d;

    logic [DESC_W-1:0]  src_desc_q, dst_desc_q;
    logic [NBUF_W-1:0]  side_idx [SIDE_N];
    logic [SIDE_N-1:0]  side_adv;
    logic               idx_clear;
    logic               in_order;
    logic               rsp_ok;
    logic               rsp_flag;
    logic               tmr_load, tmr_tick, tmr_expired;
    logic [OFS_W-1:0]   src_ofs, dst_ofs;
    chan_status_e       status_e;

    assign in_order = (cfg_period != '0);
    assign rsp_ok   = mem_rsp_valid && !mem_rsp_err;
    assign rsp_flag = mem_rsp_rdata[FLAG_BIT];

    // ------------------------------------------------------------------
    // Slot indices, one ring per side
    // ------------------------------------------------------------------
    assign idx_clear = (state_q == S_IDLE);

    assign side_adv[SIDE_SRC] =
        ((state_q == S_SRC_RSP) && rsp_ok && !rsp_flag && !in_order) ||
        ((state_q == S_DST_UPD_RSP) && rsp_ok && cfg_run);
    assign side_adv[SIDE_DST] =
        ((state_q == S_DST_RSP) && rsp_ok && rsp_flag && !in_order) ||
        ((state_q == S_DST_UPD_RSP) && rsp_ok && cfg_run);

    for (genvar s = 0; s < SIDE_N; s++) begin : g_side
        chbuf_ring_index #(.W(NBUF_W)) u_ring (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (idx_clear),
            .advance (side_adv[s]),
            .limit   (cfg_nbufs),
            .idx     (side_idx[s])
        );
    end

    // ------------------------------------------------------------------
    // Retry pause for in-order polling
    // ------------------------------------------------------------------
    assign tmr_load = in_order &&
        (((state_q == S_SRC_RSP) && rsp_ok && !rsp_flag) ||
         ((state_q == S_DST_RSP) && rsp_ok && rsp_flag));
    assign tmr_tick = (state_q == S_SRC_WAIT) || (state_q == S_DST_WAIT);

    chbuf_poll_timer #(.W(PERIOD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (cfg_period),
        .tick     (tmr_tick),
        .expired  (tmr_expired)
    );

    // ------------------------------------------------------------------
    // State register and captured descriptors
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            src_desc_q <= '0;
            dst_desc_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_SRC_RSP && rsp_ok && rsp_flag) begin
                src_desc_q <= mem_rsp_rdata;
            end
            if (state_q == S_DST_RSP && rsp_ok && !rsp_flag) begin
                dst_desc_q <= mem_rsp_rdata;
            end
        end
    end

    // ------------------------------------------------------------------
    // Next-state logic
    // ------------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        if (!cfg_run) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:        state_d = S_SRC_REQ;
                S_SRC_REQ:     if (mem_req_ready) state_d = S_SRC_RSP;
                S_SRC_RSP: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err)   state_d = S_ERR_SRC_DESC;
                        else if (rsp_flag) state_d = S_DST_REQ;
                        else if (in_order) state_d = S_SRC_WAIT;
                        else               state_d = S_SRC_REQ;
                    end
                end
                S_SRC_WAIT:    if (tmr_expired) state_d = S_SRC_REQ;
                S_DST_REQ:     if (mem_req_ready) state_d = S_DST_RSP;
                S_DST_RSP: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err)    state_d = S_ERR_DST_DESC;
                        else if (!rsp_flag) state_d = S_COPY_GO;
                        else if (in_order)  state_d = S_DST_WAIT;
                        else                state_d = S_DST_REQ;
                    end
                end
                S_DST_WAIT:    if (tmr_expired) state_d = S_DST_REQ;
                S_COPY_GO:     state_d = S_COPY_WAIT;
                S_COPY_WAIT: begin
                    if (copy_done) begin
                        if (copy_src_err)      state_d = S_ERR_SRC_DATA;
                        else if (copy_dst_err) state_d = S_ERR_DST_DATA;
                        else                   state_d = S_SRC_UPD_REQ;
                    end
                end
                S_SRC_UPD_REQ: if (mem_req_ready) state_d = S_SRC_UPD_RSP;
                S_SRC_UPD_RSP: begin
                    if (mem_rsp_valid) begin
                        state_d = mem_rsp_err ? S_ERR_SRC_DESC : S_DST_UPD_REQ;
                    end
                end
                S_DST_UPD_REQ: if (mem_req_ready) state_d = S_DST_UPD_RSP;
                S_DST_UPD_RSP: begin
                    if (mem_rsp_valid) begin
                        state_d = mem_rsp_err ? S_ERR_DST_DESC : S_SRC_REQ;
                    end
                end
                S_ERR_SRC_DESC, S_ERR_DST_DESC,
                S_ERR_SRC_DATA, S_ERR_DST_DATA: state_d = state_q;
                default:       state_d = S_IDLE;
            endcase
        end
    end

    // ------------------------------------------------------------------
    // Outputs
    // ------------------------------------------------------------------
    assign src_ofs = {side_idx[SIDE_SRC], {SLOT_SHIFT{1'b0}}};
    assign dst_ofs = {side_idx[SIDE_DST], {SLOT_SHIFT{1'b0}}};

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        copy_start    = 1'b0;
        status_e      = CH_BUSY;
        unique case (state_q)
            S_IDLE:         status_e = CH_IDLE;
            S_SRC_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = cfg_src_base + ADDR_W'(src_ofs);
            end
            S_DST_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = cfg_dst_base + ADDR_W'(dst_ofs);
            end
            S_SRC_UPD_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = cfg_src_base + ADDR_W'(src_ofs);
                mem_req_wdata = {1'b0, src_desc_q[FLAG_BIT-1:0]};
            end
            S_DST_UPD_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = cfg_dst_base + ADDR_W'(dst_ofs);
                mem_req_wdata = {1'b1, dst_desc_q[FLAG_BIT-1:0]};
            end
            S_COPY_GO:      copy_start = 1'b1;
            S_ERR_SRC_DESC: status_e = CH_SRC_DESC_ERR;
            S_ERR_DST_DESC: status_e = CH_DST_DESC_ERR;
            S_ERR_SRC_DATA: status_e = CH_SRC_DATA_ERR;
            S_ERR_DST_DATA: status_e = CH_DST_DATA_ERR;
            default:        status_e = CH_BUSY;
        endcase
    end

    assign copy_src_addr = src_desc_q[BUF_ADDR_W-1:0];
    assign copy_dst_addr = dst_desc_q[BUF_ADDR_W-1:0];
    assign status        = status_e;
    assign irq           = (state_q == S_ERR_SRC_DESC) || (state_q == S_ERR_DST_DESC) ||
                           (state_q == S_ERR_SRC_DATA) || (state_q == S_ERR_DST_DATA);

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !cfg_run)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
             $stable(mem_req_wdata)));

    assert_copy_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        copy_start |=> !copy_start);

    assert_run_off_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_run |=> (status == 3'd0 && !mem_req_valid && !copy_start));

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(mem_rsp_valid && mem_rsp_err) ||
                        $past(copy_done && (copy_src_err || copy_dst_err))));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cfg_run) |=> (irq && $stable(status)));

endmodule

// File: tb/chbuf_scanner_tb.sv
module chbuf_scanner_tb;

    localparam logic [47:0] SRC_BASE = 48'h0000_0001_0000;
    localparam logic [47:0] DST_BASE = 48'h0000_0002_0000;

    // {period[35:28], nbufs[27:24], src_full[23:16], dst_full[15:8], exp_src[7:4], exp_dst[3:0]}
    localparam int NVEC = 5;
    localparam logic [35:0] VEC [NVEC] = '{
        {8'd0, 4'd8, 8'h01, 8'h00, 4'd0, 4'd0},
        {8'd0, 4'd8, 8'h20, 8'h07, 4'd5, 4'd3},
        {8'd0, 4'd4, 8'h88, 8'h0E, 4'd3, 4'd0},
        {8'd4, 4'd8, 8'hFF, 8'h00, 4'd0, 4'd0},
        {8'd0, 4'd6, 8'h30, 8'h1F, 4'd4, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [7:0]  nbufs = 8'd4;
    logic [15:0] period = 16'd0;
    logic        req_valid, req_ready, req_write;
    logic [47:0] req_addr;
    logic [63:0] req_wdata;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err;
    logic        cp_start;
    logic [47:0] cp_src, cp_dst;
    logic        cp_done;
    logic        cp_serr_o, cp_derr_o;
    logic [2:0]  status;
    logic        irq;

    // bench controls
    logic        load_req = 1'b0;
    logic [7:0]  ld_sfull = 8'h00;
    logic [7:0]  ld_dfull = 8'h00;
    logic        stall_en = 1'b0;
    logic        err_en = 1'b0;
    logic        err_wr_only = 1'b0;
    logic [47:0] err_addr = '0;
    int          cp_lat = 3;
    logic        cp_serr = 1'b0;
    logic        cp_derr = 1'b0;

    // model state
    logic [63:0] src_mem [8];
    logic [63:0] dst_mem [8];
    int          cyc;
    int          cp_cnt;
    int          cp_count;
    logic [47:0] cp_src_log [16];
    logic [47:0] cp_dst_log [16];
    int          src0_reads;
    int          src0_last;
    int          src0_prev;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign req_ready = !stall_en || cyc[0];

    chbuf_scanner u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_run       (run),
        .cfg_src_base  (SRC_BASE),
        .cfg_dst_base  (DST_BASE),
        .cfg_nbufs     (nbufs),
        .cfg_period    (period),
        .mem_req_valid (req_valid),
        .mem_req_ready (req_ready),
        .mem_req_write (req_write),
        .mem_req_addr  (req_addr),
        .mem_req_wdata (req_wdata),
        .mem_rsp_valid (rsp_valid),
        .mem_rsp_rdata (rsp_rdata),
        .mem_rsp_err   (rsp_err),
        .copy_start    (cp_start),
        .copy_src_addr (cp_src),
        .copy_dst_addr (cp_dst),
        .copy_done     (cp_done),
        .copy_src_err  (cp_serr_o),
        .copy_dst_err  (cp_derr_o),
        .status        (status),
        .irq           (irq)
    );

    function automatic logic [47:0] sbuf(int i);
        return 48'h0000_1000_0000 + 48'(i) * 48'h100;
    endfunction

    function automatic logic [47:0] dbuf(int i);
        return 48'h0000_2000_0000 + 48'(i) * 48'h100;
    endfunction

    // memory and copy-engine model
    always @(posedge clk) begin
        cyc       <= cyc + 1;
        rsp_valid <= 1'b0;
        rsp_err   <= 1'b0;
        cp_done   <= 1'b0;
        cp_serr_o <= 1'b0;
        cp_derr_o <= 1'b0;
        if (load_req) begin
            for (int i = 0; i < 8; i++) begin
                src_mem[i] <= {ld_sfull[i], 15'd0, sbuf(i)};
                dst_mem[i] <= {ld_dfull[i], 15'd0, dbuf(i)};
            end
            cp_count   <= 0;
            src0_reads <= 0;
        end else begin
            if (req_valid && req_ready) begin
                logic hit_err;
                logic [2:0] slot;
                hit_err   = err_en && (req_addr == err_addr) && (req_write || !err_wr_only);
                slot      = req_addr[8:6];
                rsp_valid <= 1'b1;
                rsp_err   <= hit_err;
                rsp_rdata <= '0;
                if (req_addr >= SRC_BASE && req_addr < SRC_BASE + 48'd512) begin
                    if (req_write && !hit_err) src_mem[slot] <= req_wdata;
                    else rsp_rdata <= src_mem[slot];
                    if (!req_write && slot == 3'd0) begin
                        src0_reads <= src0_reads + 1;
                        src0_prev  <= src0_last;
                        src0_last  <= cyc;
                    end
                end else if (req_addr >= DST_BASE && req_addr < DST_BASE + 48'd512) begin
                    if (req_write && !hit_err) dst_mem[slot] <= req_wdata;
                    else rsp_rdata <= dst_mem[slot];
                end
            end
            if (cp_start) begin
                if (cp_count < 16) begin
                    cp_src_log[cp_count] <= cp_src;
                    cp_dst_log[cp_count] <= cp_dst;
                end
                cp_count <= cp_count + 1;
            end
        end
        if (cp_start) begin
            cp_cnt <= cp_lat;
        end else if (cp_cnt != 0) begin
            cp_cnt <= cp_cnt - 1;
            if (cp_cnt == 1) begin
                cp_done   <= 1'b1;
                cp_serr_o <= cp_serr;
                cp_derr_o <= cp_derr;
            end
        end
    end

    initial begin
        cyc = 0;
        cp_cnt = 0;
        cp_count = 0;
        src0_reads = 0;
        src0_last = 0;
        src0_prev = 0;
        rsp_rdata = '0;
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic load_mem(input logic [7:0] sf, input logic [7:0] df);
        @(negedge clk);
        ld_sfull = sf;
        ld_dfull = df;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    task automatic start(input logic [15:0] p, input logic [7:0] n,
                         input logic [7:0] sf, input logic [7:0] df);
        @(negedge clk);
        run = 1'b0;
        repeat (2) @(negedge clk);
        period = p;
        nbufs  = n;
        load_mem(sf, df);
        run = 1'b1;
    endtask

    task automatic wait_status(input logic [2:0] exp, input int maxc);
        for (int i = 0; i < maxc && status != exp; i++) @(negedge clk);
    endtask

    task automatic wait_copies(input int n, input int maxc);
        for (int i = 0; i < maxc && cp_count < n; i++) @(negedge clk);
    endtask

    task automatic err_case(input string req, input logic [2:0] exp);
        start(16'd0, 8'd4, 8'h01, 8'h00);
        wait_status(exp, 500);
        chk(status == exp, req, 64'(status), 64'(exp));
        chk(irq == 1'b1, "R10 irq in error", 64'(irq), 64'd1);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk(status == 3'd0, "R11 idle after run low", 64'(status), 64'd0);
        chk(irq == 1'b0, "R10 irq clear when idle", 64'(irq), 64'd0);
        err_en = 1'b0;
        err_wr_only = 1'b0;
        cp_serr = 1'b0;
        cp_derr = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R12 watchdog expired act=%0d exp=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        chk(status == 3'd0, "R12 reset status", 64'(status), 64'd0);
        chk(irq == 1'b0, "R12 reset irq", 64'(irq), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_valid == 1'b0 && cp_start == 1'b0, "R12 no activity after reset",
            64'({req_valid, cp_start}), 64'd0);
        chk(status == 3'd0, "R12 idle with run low", 64'(status), 64'd0);

        // vector table: first copy pair and descriptor write-back
        for (int v = 0; v < NVEC; v++) begin
            logic [35:0] e;
            int es, ed;
            e  = VEC[v];
            es = int'(e[7:4]);
            ed = int'(e[3:0]);
            stall_en = v[0];
            start(16'(e[35:28]), 8'(e[27:24]), e[23:16], e[15:8]);
            for (int i = 0; i < 3000 && !dst_mem[ed][63]; i++) @(negedge clk);
            @(negedge clk);
            chk(status == 3'd1, "R12 busy while running", 64'(status), 64'd1);
            chk(cp_src_log[0] == sbuf(es), "R1 R3 source pick", 64'(cp_src_log[0]),
                64'(sbuf(es)));
            chk(cp_dst_log[0] == dbuf(ed), "R1 R2 destination pick", 64'(cp_dst_log[0]),
                64'(dbuf(ed)));
            chk(src_mem[es] == {1'b0, 15'd0, sbuf(es)}, "R5 source write-back",
                src_mem[es], {1'b0, 15'd0, sbuf(es)});
            chk(dst_mem[ed] == {1'b1, 15'd0, dbuf(ed)}, "R5 destination write-back",
                dst_mem[ed], {1'b1, 15'd0, dbuf(ed)});
        end
        stall_en = 1'b0;

        // R3: round-robin continues after the last slot used
        start(16'd0, 8'd8, 8'h09, 8'h00);
        wait_copies(2, 2000);
        chk(cp_src_log[1] == sbuf(3) && cp_dst_log[1] == dbuf(1), "R3 second pair",
            64'(cp_src_log[1]), 64'(sbuf(3)));

        // R3: both rings wrap after nbufs-1
        start(16'd0, 8'd4, 8'h0F, 8'h00);
        wait_copies(4, 3000);
        repeat (100) @(negedge clk);
        chk(cp_count == 4, "R3 stalls after four copies", 64'(cp_count), 64'd4);
        load_mem(8'h01, 8'h0E);
        wait_copies(1, 2000);
        chk(cp_src_log[0] == sbuf(0) && cp_dst_log[0] == dbuf(0), "R3 wrap to slot 0",
            64'(cp_dst_log[0]), 64'(dbuf(0)));

        // R4: in-order polling with exact pause
        start(16'd5, 8'd4, 8'h02, 8'h00);
        for (int i = 0; i < 2000 && src0_reads < 3; i++) @(negedge clk);
        chk(src0_last - src0_prev == 7, "R4 poll spacing", 64'(src0_last - src0_prev), 64'd7);
        chk(cp_count == 0, "R4 no skip to later slot", 64'(cp_count), 64'd0);
        load_mem(8'h03, 8'h00);
        wait_copies(2, 2000);
        chk(cp_src_log[0] == sbuf(0) && cp_dst_log[0] == dbuf(0), "R4 first in order",
            64'(cp_src_log[0]), 64'(sbuf(0)));
        chk(cp_src_log[1] == sbuf(1) && cp_dst_log[1] == dbuf(1), "R4 second in order",
            64'(cp_src_log[1]), 64'(sbuf(1)));

        // R6: one launch per completion with a long copy
        cp_lat = 40;
        start(16'd0, 8'd4, 8'h0F, 8'h00);
        wait_copies(1, 500);
        repeat (20) @(negedge clk);
        chk(cp_count == 1, "R6 no second launch before done", 64'(cp_count), 64'd1);

        // R11: run low during copy, late completion changes nothing
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk(status == 3'd0, "R11 idle next cycle", 64'(status), 64'd0);
        repeat (60) @(negedge clk);
        chk(src_mem[0][63] == 1'b1 && dst_mem[0][63] == 1'b0, "R11 descriptors untouched",
            64'({src_mem[0][63], dst_mem[0][63]}), 64'd2);
        cp_lat = 3;

        // R8 / R9 / R10: error reporting
        err_en = 1'b1; err_addr = SRC_BASE;
        start(16'd0, 8'd4, 8'h01, 8'h00);
        wait_status(3'd2, 500);
        repeat (10) @(negedge clk);
        chk(status == 3'd2 && irq, "R10 error holds", 64'(status), 64'd2);
        err_en = 1'b0;
        @(negedge clk); run = 1'b0;
        repeat (5) @(negedge clk);

        err_en = 1'b1; err_addr = SRC_BASE;
        err_case("R8 src descriptor read error", 3'd2);
        err_en = 1'b1; err_addr = DST_BASE;
        err_case("R8 dst descriptor read error", 3'd3);
        err_en = 1'b1; err_wr_only = 1'b1; err_addr = SRC_BASE;
        err_case("R8 src descriptor write error", 3'd2);
        err_en = 1'b1; err_wr_only = 1'b1; err_addr = DST_BASE;
        err_case("R8 dst descriptor write error", 3'd3);
        cp_serr = 1'b1;
        err_case("R9 source data error", 3'd4);
        cp_derr = 1'b1;
        err_case("R9 destination data error", 3'd5);
        cp_serr = 1'b1; cp_derr = 1'b1;
        err_case("R9 source error wins", 3'd4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule